// File: doc/BRIEF.md
# Bank Readout Mux and Serializer

This block gathers conversion results from one bank of analog-to-digital converters, where every converter is time-shared by several input channels. Each converter port hands over a 12-bit result together with a small channel tag and a one-cycle valid strobe. The block parks each result in a short per-port holding buffer. It then visits the converters in a fixed order to build a frame that holds one word for every channel of the bank.

Every result leaves as a 14-bit line word: a 2-bit marker on top of the 12 data bits. A receiver locks to frames by finding the word whose marker says "first of frame". The words are shifted out most significant bit first, one bit per bit strobe, on a single serial line that feeds a differential transmitter. With 32 channels sampled at 2 MSPS each, one frame of 32 words of 14 bits fills exactly the 500 ns that 896 Mbps allows. The serial line therefore never has to wait for data and never runs ahead of it.

From reset the line carries an all-zero idle word. Frames start only when every converter port holds a result for channel tag 0. If a result is missing when its slot comes round, the block fills the slot with a recognizable error word and records the event.

Top module: `bank_serializer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ser_bit` is 0, `bit_stb` is 1 and `underrun` is 0.
- R2: `bit_stb` is high for exactly one cycle in every CLK_PER_BIT cycles. `ser_bit` changes only on entry to a strobe cycle. Each 14-bit word is sent bit 13 first and bit 0 last.
- R3: After reset the line repeats the idle word 14'h0000. The first word after the word boundary at which every port holds a tag-0 sample is slot 0 of a frame.
- R4: Until the first frame word has been issued, a sample whose tag is not 0 is not stored, so it neither triggers the start nor appears in any frame.
- R5: Slot s of a frame (s = 0..31) carries the converter s mod 8 with channel tag s div 8.
- R6: In a delivered word, bits 13:12 are the marker and bits 11:0 are the sample. The marker is 2'b10 in slot 0 and 2'b01 in every other slot.
- R7: When the head of the slot's port buffer is empty, or holds a different tag, the slot sends 14'h0FFF (marker 2'b00). The held sample stays where it is.
- R8: `underrun` rises in the cycle after the load of an error word and stays high until reset.
- R9: Each port buffer holds two samples. A sample that arrives while the buffer is full, with no removal in that cycle, is dropped.
- R10: When a sample arrives at a port in the same cycle that its head is taken for a slot, the head is sent and the new sample is kept.
- R11: Once started, frames follow each other with no idle words between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one serial bit lasts CLK_PER_BIT cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 8 | Per-port strobe: a sample is offered this cycle |
| smp_data | input | 96 | Per-port 12-bit sample; port p uses bits 12p+11..12p |
| smp_tag | input | 16 | Per-port 2-bit channel tag; port p uses bits 2p+1..2p |
| ser_bit | output | 1 | Serial data bit to the line driver |
| bit_stb | output | 1 | High in the first cycle of each new serial bit |
| underrun | output | 1 | Sticky flag: at least one error word was sent |

## Verification
The interesting coincidence is a sample arriving at a port in the very cycle that port's head is taken for its slot. The buffer must both shift out the head and store the newcomer. The bench provokes this by holding back one port's delivery by a single clock, so that the write lands on the word-load edge. It judges the result by checking that the outgoing slot carries the old sample and the following frame slot carries the new one. A second coincidence, an error word falling in slot 0, is driven by withholding a tag-0 sample. It must come out as 14'h0FFF, not as a first-of-frame word.

// File: rtl/bs_pkg.sv
// Shared constants for the bank serializer.
// Assumes the marker field is two bits wide and sits above the sample.
package bs_pkg;
    localparam int MARK_W = 2;
    typedef enum logic [MARK_W-1:0] {
        MARK_NONE  = 2'b00,
        MARK_NEXT  = 2'b01,
        MARK_FIRST = 2'b10
    } marker_e;
    localparam int BUF_DEPTH = 2;
endpackage

// File: rtl/bs_hold_buf.sv
// Two-entry in-order holding buffer for one converter port.
// Stores sample plus tag; a write when full is lost unless the head is
// removed in the same cycle. Assumes pop is only raised when non-empty.
module bs_hold_buf #(
    parameter int SAMPLE_W = 12,
    parameter int TAG_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] push_data,
    input  logic [TAG_W-1:0]    push_tag,
    input  logic                pop,
    output logic                head_valid,
    output logic [SAMPLE_W-1:0] head_data,
    output logic [TAG_W-1:0]    head_tag
);
    localparam int ENT_W = SAMPLE_W + TAG_W;

    logic [ENT_W-1:0] ent [bs_pkg::BUF_DEPTH];
    logic [1:0]       fill;
    logic             take, give;
    logic [ENT_W-1:0] new_ent;

    // decide which of write and removal actually happen this cycle
    always_comb begin
        give    = pop && (fill != 2'd0);
        take    = push && ((fill < 2'(bs_pkg::BUF_DEPTH)) || give);
        new_ent = {push_tag, push_data};
    end

    // update storage and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill   <= 2'd0;
            ent[0] <= '0;
            ent[1] <= '0;
        end else begin
            unique case ({take, give})
                2'b10: begin
                    ent[fill[0]] <= new_ent;
                    fill         <= fill + 2'd1;
                end
                2'b01: begin
                    ent[0] <= ent[1];
                    fill   <= fill - 2'd1;
                end
                2'b11: begin
                    if (fill == 2'd1) begin
                        ent[0] <= new_ent;
                    end else begin
                        ent[0] <= ent[1];
                        ent[1] <= new_ent;
                    end
                end
                default: ;
            endcase
        end
    end

    assign head_valid = (fill != 2'd0);
    assign {head_tag, head_data} = ent[0];
endmodule

// File: rtl/bs_word_sched.sv
// Frame scheduler: picks the word for the next slot when the shifter asks.
// Slot s serves port s mod N_ADC with tag s div N_ADC. Assumes N_ADC and
// CH_PER_ADC are powers of two and CH_PER_ADC is at least 2.
module bs_word_sched #(
    parameter int N_ADC      = 8,
    parameter int CH_PER_ADC = 4,
    parameter int SAMPLE_W   = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          word_req,
    input  logic                          head_valid [N_ADC],
    input  logic [SAMPLE_W-1:0]           head_data  [N_ADC],
    input  logic [$clog2(CH_PER_ADC)-1:0] head_tag   [N_ADC],
    output logic                          pop        [N_ADC],
    output logic [SAMPLE_W+bs_pkg::MARK_W-1:0] word,
    output logic                          running,
    output logic                          underrun
);
    import bs_pkg::*;
    localparam int SLOTS  = N_ADC * CH_PER_ADC;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ADC_W  = (N_ADC > 1) ? $clog2(N_ADC) : 1;
    localparam int TAG_W  = $clog2(CH_PER_ADC);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot, cur;
    logic [ADC_W-1:0]  sel;
    logic [TAG_W-1:0]  want;
    logic              all_ready, active, hit;

    // work out the slot in play and whether its sample is at hand
    always_comb begin
        all_ready = 1'b1;
        for (int i = 0; i < N_ADC; i++) all_ready &= head_valid[i];
        active = running || all_ready;
        cur    = running ? slot : '0;
        sel    = cur[ADC_W-1:0];
        want   = cur[SLOT_W-1:SLOT_W-TAG_W];
        hit    = head_valid[sel] && (head_tag[sel] == want);
        if (!active)
            word = '0;
        else if (hit)
            word = {(cur == '0) ? MARK_FIRST : MARK_NEXT, head_data[sel]};
        else
            word = {MARK_NONE, {SAMPLE_W{1'b1}}};
    end

    // one removal strobe per port, only on a matching slot load
    for (genvar a = 0; a < N_ADC; a++) begin : g_pop
        assign pop[a] = word_req && active && hit && (sel == ADC_W'(a));
    end

    // advance the slot, latch the start and the sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= '0;
            running  <= 1'b0;
            underrun <= 1'b0;
        end else if (word_req && active) begin
            running  <= 1'b1;
            slot     <= (cur == SLOT_LAST) ? '0 : cur + 1'b1;
            underrun <= underrun || !hit;
        end
    end
endmodule

// File: rtl/bs_shifter.sv
// Bit-rate divider and MSB-first shift register.
// Holds each bit for CLK_PER_BIT cycles and asks for a new word as the
// last bit of the current one ends. Reset shows the all-zero word.
module bs_shifter #(
    parameter int WORD_W      = 14,
    parameter int CLK_PER_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_req,
    output logic              ser_bit,
    output logic              bit_stb
);
    localparam int DIV_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_BIT - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_W - 1);

    logic [DIV_W-1:0]  div;
    logic [CNT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] sh;
    logic              tick;

    // end of a bit period and end of a word
    always_comb begin
        tick     = (div == DIV_LAST);
        word_req = tick && (bit_idx == BIT_LAST);
    end

    // divider, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div     <= '0;
            bit_idx <= '0;
            sh      <= '0;
        end else begin
            div <= tick ? '0 : div + 1'b1;
            if (word_req) begin
                sh      <= word_in;
                bit_idx <= '0;
            end else if (tick) begin
                sh      <= {sh[WORD_W-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign ser_bit = sh[WORD_W-1];
    assign bit_stb = (div == '0);
endmodule

// File: rtl/bank_serializer.sv
// Top: per-port holding buffers, frame scheduler and serial shifter.
// Before the first frame only tag-0 samples are accepted. Assumes a port
// raises smp_valid for one cycle per sample.
module bank_serializer #(
    parameter int N_ADC       = 8,
    parameter int CH_PER_ADC  = 4,
    parameter int SAMPLE_W    = 12,
    parameter int CLK_PER_BIT = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_ADC-1:0]                       smp_valid,
    input  logic [N_ADC*SAMPLE_W-1:0]              smp_data,
    input  logic [N_ADC*$clog2(CH_PER_ADC)-1:0]    smp_tag,
    output logic                                   ser_bit,
    output logic                                   bit_stb,
    output logic                                   underrun
);
    localparam int TAG_W  = $clog2(CH_PER_ADC);
    localparam int WORD_W = SAMPLE_W + bs_pkg::MARK_W;

    logic                hv   [N_ADC];
    logic [SAMPLE_W-1:0] hd   [N_ADC];
    logic [TAG_W-1:0]    ht   [N_ADC];
    logic                pop  [N_ADC];
    logic [WORD_W-1:0]   word;
    logic                word_req, running;

    for (genvar a = 0; a < N_ADC; a++) begin : g_port
        logic [TAG_W-1:0] tag_in;
        logic             push;
        // filter out non-zero tags until the first frame word is out
        always_comb begin
            tag_in = smp_tag[a*TAG_W +: TAG_W];
            push   = smp_valid[a] && (running || (tag_in == '0));
        end
        bs_hold_buf #(.SAMPLE_W(SAMPLE_W), .TAG_W(TAG_W)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push),
            .push_data  (smp_data[a*SAMPLE_W +: SAMPLE_W]),
            .push_tag   (tag_in),
            .pop        (pop[a]),
            .head_valid (hv[a]),
            .head_data  (hd[a]),
            .head_tag   (ht[a])
        );
    end

    bs_word_sched #(.N_ADC(N_ADC), .CH_PER_ADC(CH_PER_ADC), .SAMPLE_W(SAMPLE_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_req   (word_req),
        .head_valid (hv),
        .head_data  (hd),
        .head_tag   (ht),
        .pop        (pop),
        .word       (word),
        .running    (running),
        .underrun   (underrun)
    );

    bs_shifter #(.WORD_W(WORD_W), .CLK_PER_BIT(CLK_PER_BIT)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (word),
        .word_req (word_req),
        .ser_bit  (ser_bit),
        .bit_stb  (bit_stb)
    );
endmodule

// File: rtl/bank_serializer_chk.sv
// Timing properties of the serializer, attached to every instance by bind.
// Watches the line outputs plus the scheduler's start state and the
// shifter's word request.
module bank_serializer_chk #(
    parameter int CLK_PER_BIT = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ser_bit,
    input logic bit_stb,
    input logic underrun,
    input logic running,
    input logic word_req
);
    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R7
    underrun_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(word_req));
    // R2
    stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((CLK_PER_BIT > 1) && bit_stb) |=> !bit_stb);
    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |-> $stable(ser_bit));
    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !ser_bit);
    // R3
    start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(word_req));
    // R11
    stay_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
endmodule

bind bank_serializer bank_serializer_chk #(.CLK_PER_BIT(CLK_PER_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_bit  (ser_bit),
    .bit_stb  (bit_stb),
    .underrun (underrun),
    .running  (running),
    .word_req (word_req)
);

// File: tb/bank_serializer_test.sv
// Self-checking bench: a frame table drives six frames, then directed checks.
module bank_serializer_test;
    localparam int NA = 8, SW = 12, TW = 2, FIRST = 2, NFR = 6;
    localparam int NWORDS = FIRST + 32 * NFR;

    // {seed[20:9], skip_port[8:5] (F = none), skip_tag[4:3], coll[2], extra[1], exp_underrun[0]}
    localparam logic [20:0] VEC [NFR] = '{
        {12'h100, 4'hF, 2'd0, 1'b0, 1'b0, 1'b0},
        {12'hA50, 4'hF, 2'd0, 1'b1, 1'b0, 1'b0},
        {12'h3C3, 4'hF, 2'd0, 1'b0, 1'b1, 1'b0},
        {12'h7FE, 4'd5, 2'd2, 1'b0, 1'b0, 1'b1},
        {12'hFF0, 4'hF, 2'd0, 1'b0, 1'b0, 1'b1},
        {12'h001, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NA-1:0]    smp_valid = '0;
    logic [NA*SW-1:0] smp_data = '0;
    logic [NA*TW-1:0] smp_tag = '0;
    logic ser_bit, bit_stb, underrun;

    int checks = 0, fails = 0;
    int nwords = 0, nbits = 0;
    logic [13:0] cur = '0;
    logic [13:0] got [NWORDS+64];

    always #2.5 clk = ~clk;

    bank_serializer uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_tag(smp_tag), .ser_bit(ser_bit), .bit_stb(bit_stb), .underrun(underrun)
    );

    // collect serial bits into words, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            nbits  <= 0;
            nwords <= 0;
        end else if (bit_stb) begin
            if (nbits == 13) begin
                if (nwords < NWORDS + 64) got[nwords] <= {cur[12:0], ser_bit};
                nwords <= nwords + 1;
                nbits  <= 0;
            end else begin
                cur   <= {cur[12:0], ser_bit};
                nbits <= nbits + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] sdata(input int f, input int a, input int t);
        return 12'(VEC[f][20:9] + 12'(a * 16 + t));
    endfunction

    function automatic logic [13:0] exp_word(input int w);
        int f, s, a, t;
        if (w < FIRST) return 14'h0000;
        f = (w - FIRST) / 32; s = (w - FIRST) % 32; a = s % 8; t = s / 8;
        if (VEC[f][8:5] == 4'(a) && VEC[f][4:3] == 2'(t)) return 14'h0FFF;
        return {(s == 0) ? 2'b10 : 2'b01, sdata(f, a, t)};
    endfunction

    // offer one tag group of frame f; inputs change only at negedges
    task automatic deliver(input int f, input int t);
        for (int a = 0; a < NA; a++) begin
            smp_data[a*SW +: SW] = sdata(f, a, t);
            smp_tag[a*TW +: TW]  = 2'(t);
            smp_valid[a] = !(VEC[f][8:5] == 4'(a) && VEC[f][4:3] == 2'(t))
                           && !(VEC[f][2] && a == 1);
        end
        @(negedge clk);
        smp_valid = '0;
        if (VEC[f][2]) begin
            smp_valid[1] = 1'b1;          // lands on the edge that takes port 1's head
            @(negedge clk);
            smp_valid = '0;
        end else begin
            @(negedge clk);
        end
        if (VEC[f][1]) begin
            smp_data[3*SW +: SW] = 12'hBAD;
            smp_tag[3*TW +: TW]  = 2'(t);
            smp_valid[3] = 1'b1;          // port 3 already full
            @(negedge clk);
            smp_valid = '0;
        end
    endtask

    task automatic run_all();
        int ns;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bit_stb == 1'b1, "R1 bit_stb", 32'(bit_stb), 32'd1);
        chk(ser_bit == 1'b0, "R1 ser_bit", 32'(ser_bit), 32'd0);
        chk(underrun == 1'b0, "R1 underrun", 32'(underrun), 32'd0);
        @(negedge clk);
        chk(bit_stb == 1'b0, "R2 strobe gap", 32'(bit_stb), 32'd0);

        // R4: non-zero tags before start must be thrown away
        wait (nwords == 1);
        for (int a = 0; a < NA; a++) begin
            smp_data[a*SW +: SW] = 12'h555;
            smp_tag[a*TW +: TW]  = 2'd1;
        end
        smp_valid = '1;
        @(negedge clk);
        smp_valid = '0;

        // table walk: one loop over frames and tag groups
        for (int f = 0; f < NFR; f++) begin
            for (int t = 0; t < 4; t++) begin
                if (f == 0 && t == 0) wait (nwords == FIRST);
                else wait (nwords == FIRST + 32 * f + 8 * t - 7);
                if (t == 0 && f > 0)
                    chk(underrun == VEC[f-1][0], "R8 sticky flag", 32'(underrun), 32'(VEC[f-1][0]));
                deliver(f, t);
            end
        end
        wait (nwords == NWORDS);
        chk(underrun == VEC[NFR-1][0], "R8 sticky flag", 32'(underrun), 32'(VEC[NFR-1][0]));

        for (int w = 0; w < NWORDS; w++) begin
            int f, s, a;
            string req;
            f = (w - FIRST) / 32; s = (w - FIRST) % 32; a = s % 8;
            if (w < FIRST)                       req = "R3 idle word";
            else if (exp_word(w) == 14'h0FFF)    req = "R7 error word";
            else if (f == 1 && a == 1)           req = "R10 push with pop";
            else if (f == 2 && a == 3)           req = "R9 full buffer";
            else if (s == 0)                     req = "R6 frame marker";
            else                                 req = "R5 slot order";
            chk(got[w] == exp_word(w), req, 32'(got[w]), 32'(exp_word(w)));
        end
        chk(got[FIRST] == exp_word(FIRST), "R4 start uses tag 0", 32'(got[FIRST]), 32'(exp_word(FIRST)));
        chk(got[FIRST+32][13:12] == 2'b10, "R11 back-to-back frame", 32'(got[FIRST+32]), 32'(exp_word(FIRST+32)));
        chk(got[FIRST+160] == 14'h0FFF, "R7 error in slot 0", 32'(got[FIRST+160]), 32'h0FFF);

        // R2 strobe rate: one strobe per two cycles
        ns = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bit_stb) ns++;
        end
        chk(ns == 20, "R2 strobe rate", 32'(ns), 32'd20);

        // R8 flag clears only through reset; R1 state again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(underrun == 1'b0, "R8 cleared by reset", 32'(underrun), 32'd0);
        chk(ser_bit == 1'b0 && bit_stb == 1'b1, "R1 reset outputs", {30'd0, ser_bit, bit_stb}, 32'd1);
        @(posedge clk);
        #1 rst_n = 1'b1;
        wait (nwords == 3);
        chk(got[0] == 14'h0 && got[1] == 14'h0 && got[2] == 14'h0, "R3 idle after reset",
            32'(got[2]), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog (R1..): actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule